// File: doc/BRIEF.md
# Reloadable Interval Timer with Byte-Wide Register Access

This block is a 16-bit interval timer that counts down by one on every cycle of its single clock. A CPU reaches it over an 8-bit bus with a register select, a read strobe and a write strobe. Through that bus it reads and writes a two-byte reload value, reads and restarts the live count, picks single-shot or self-reloading operation, and controls a single interrupt source. An active-low interrupt request reports the source when it is both pending and enabled.

Some accesses have side effects that software relies on. Writing the upper count byte starts a new count. Reading the lower count byte acknowledges the interrupt. The self-reloading period is the reload value plus two cycles, because the count shows zero and then all ones before it returns to the reload value. Since the two count bytes are separate reads, a two-byte sample of the count is not atomic.

Top module: `reload_timer`

## Requirements
- R1: After reset, the flag register (select 5) reads 0x00, the enable register (select 6) reads 0x80, the mode register (select 4) reads 0x00, both reload bytes (select 0 low, select 1 high) read 0xFF, and `irq_n` is 1.
- R2: A write to select 0 or to select 2 changes only the low reload byte. A write to select 2 leaves the running count and the interrupt flag unchanged.
- R3: A write to select 3 stores the byte as the high reload byte, loads the count with {written byte, low reload byte} at that clock edge, clears the interrupt flag and starts a new count.
- R4: The count falls by one on every clock. Select 2 reads its low byte and select 3 reads its high byte, so select 3 reads 0xFF in the cycle where the count is 0xFFFF.
- R5: With mode bit 6 set (self-reload) and reload value N, the count runs N..0, then 0xFFFF, then N again. The interrupt flag sets on the edge where the count leaves zero, once every N+2 cycles.
- R6: With mode bit 6 clear (single shot), the flag sets only on the first underflow after a start. The count then keeps decrementing through 0xFFFF without reloading, and later underflows do not set the flag.
- R7: A read of select 2 clears the interrupt flag at that clock edge. If an underflow falls on the same edge, the flag ends up set.
- R8: A write to select 5 clears the timer flag (bit 6) when that bit is written as 1. A bit written as 0 leaves the flag as it was.
- R9: A write to select 6 with bit 7 set enables the interrupt when bit 6 is 1. With bit 7 clear it disables the interrupt when bit 6 is 1. The enable register reads bit 7 as 1 and bit 6 as the enable.
- R10: The flag register reads bit 6 as the timer flag and bit 7 as (flag AND enable). `irq_n` is 0 exactly when the flag and the enable are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock; the count steps on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 3 | Register select |
| rd | input | 1 | Read strobe; its side effects take place at the next rising edge |
| wr | input | 1 | Write strobe; the write takes place at the next rising edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The case that matters is an acknowledge and a new underflow on the same edge. The bench reads the low count byte in exactly the cycle where the count is zero in self-reload mode, so the clear from the read and the set from the underflow meet at one edge. It then checks that `irq_n` is low and that the flag register reads 0xC0. The bench also checks a restart from a write to select 3 that arrives while a flag is pending, and confirms the flag is gone in the first cycle after that write.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;

   typedef enum logic [2:0] {
      RG_RLD_LO = 3'd0,
      RG_RLD_HI = 3'd1,
      RG_CNT_LO = 3'd2,
      RG_CNT_HI = 3'd3,
      RG_MODE   = 3'd4,
      RG_FLAG   = 3'd5,
      RG_ENA    = 3'd6
   } rtmr_reg_e;

   localparam int unsigned RTMR_SEL_W = 3;

endpackage

// File: rtl/reload_timer_regs.sv
module reload_timer_regs
   import rtmr_pkg::*;
#(
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned BYTE_W   = 8,
   parameter int unsigned MODE_BIT = 6,
   parameter int unsigned FLAG_BIT = 6,
   localparam int unsigned CNT_W   = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  sel,
   input  logic              rd,
   input  logic              wr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              flag,
   output logic [BYTE_W-1:0] rdata,
   output logic [CNT_W-1:0]  reload,
   output logic [CNT_W-1:0]  load_val,
   output logic              load,
   output logic              cont,
   output logic              ena,
   output logic              rd_ack,
   output logic              wr_ack
);

   localparam logic [SEL_W-1:0] S_RLD_LO = SEL_W'(RG_RLD_LO);
   localparam logic [SEL_W-1:0] S_RLD_HI = SEL_W'(RG_RLD_HI);
   localparam logic [SEL_W-1:0] S_CNT_LO = SEL_W'(RG_CNT_LO);
   localparam logic [SEL_W-1:0] S_CNT_HI = SEL_W'(RG_CNT_HI);
   localparam logic [SEL_W-1:0] S_MODE   = SEL_W'(RG_MODE);
   localparam logic [SEL_W-1:0] S_FLAG   = SEL_W'(RG_FLAG);
   localparam logic [SEL_W-1:0] S_ENA    = SEL_W'(RG_ENA);

   logic [BYTE_W-1:0] rld_lo, rld_hi, mode_q;
   logic              ena_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rld_lo <= '1;
         rld_hi <= '1;
         mode_q <= '0;
         ena_q  <= 1'b0;
      end else if (wr) begin
         case (sel)
            S_RLD_LO, S_CNT_LO: rld_lo <= wdata;
            S_RLD_HI, S_CNT_HI: rld_hi <= wdata;
            S_MODE:             mode_q <= wdata;
            S_ENA: begin
               if (wdata[FLAG_BIT]) ena_q <= wdata[BYTE_W-1];
            end
            default: ;
         endcase
      end
   end

   assign reload   = {rld_hi, rld_lo};
   assign load_val = {wdata, rld_lo};
   assign load     = wr && (sel == S_CNT_HI);
   assign cont     = mode_q[MODE_BIT];
   assign ena      = ena_q;
   assign rd_ack   = rd && (sel == S_CNT_LO);
   assign wr_ack   = wr && (sel == S_FLAG) && wdata[FLAG_BIT];

   always_comb begin
      rdata = '0;
      case (sel)
         S_RLD_LO: rdata = rld_lo;
         S_RLD_HI: rdata = rld_hi;
         S_CNT_LO: rdata = cnt[BYTE_W-1:0];
         S_CNT_HI: rdata = cnt[CNT_W-1:BYTE_W];
         S_MODE:   rdata = mode_q;
         S_FLAG: begin
            rdata[FLAG_BIT]   = flag;
            rdata[BYTE_W-1]   = flag & ena_q;
         end
         S_ENA: begin
            rdata[FLAG_BIT]   = ena_q;
            rdata[BYTE_W-1]   = 1'b1;
         end
         default: rdata = '0;
      endcase
   end

   // R2
   rld_lo_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == S_CNT_LO) |=> (rld_lo == $past(wdata)) && $stable(rld_hi));

endmodule

// File: rtl/reload_timer_cnt.sv
module reload_timer_cnt #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload,
   input  logic             cont,
   output logic [CNT_W-1:0] cnt,
   output logic             uflow
);

   logic [CNT_W-1:0] cnt_q;
   logic             wrapped;

   assign uflow = (cnt_q == '0) && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '1;
         wrapped <= 1'b0;
      end else begin
         wrapped <= uflow;
         if (load)
            cnt_q <= load_val;
         else if (wrapped && cont)
            cnt_q <= reload;
         else
            cnt_q <= cnt_q - 1'b1;
      end
   end

   assign cnt = cnt_q;

   // R3
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt == $past(load_val));

   // R4
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && !load) |=> cnt == '1);

   // R5
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '1 && wrapped && cont && !load) |=> cnt == $past(reload));

endmodule

// File: rtl/reload_timer_irq.sv
module reload_timer_irq #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic uflow,
   input  logic cont,
   input  logic load,
   input  logic rd_ack,
   input  logic wr_ack,
   input  logic ena,
   output logic flag,
   output logic irq_n
);

   logic armed, flag_q, set_ev, active;

   assign set_ev = uflow && (cont || armed);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (load)       armed <= 1'b1;
         else if (uflow) armed <= 1'b0;

         if (load)                  flag_q <= 1'b0;
         else if (set_ev)           flag_q <= 1'b1;
         else if (rd_ack || wr_ack) flag_q <= 1'b0;
      end
   end

   assign flag   = flag_q;
   assign active = flag_q & ena;

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b1;
            else        irq_q <= ~active;
         end
         assign irq_n = irq_q;
      end else begin : g_irq_comb
         assign irq_n = ~active;
      end
   endgenerate

   // R3
   restart_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !flag);

   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uflow && cont) |=> flag);

   // R6
   one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uflow && !cont && !armed && !flag) |=> !flag);

   // R5
   rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(uflow));

endmodule

// File: rtl/reload_timer.sv
module reload_timer
   import rtmr_pkg::*;
#(
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned BYTE_W   = 8,
   parameter int unsigned MODE_BIT = 6,
   parameter int unsigned FLAG_BIT = 6,
   parameter bit          IRQ_REG  = 1'b0,
   localparam int unsigned CNT_W   = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  sel,
   input  logic              rd,
   input  logic              wr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   output logic              irq_n
);

   generate
      if (SEL_W < RTMR_SEL_W) begin : g_bad_sel
         $error("reload_timer: SEL_W too small for the register map");
      end
      if (MODE_BIT >= BYTE_W - 1) begin : g_bad_mode
         $error("reload_timer: MODE_BIT must sit below the top data bit");
      end
      if (FLAG_BIT >= BYTE_W - 1) begin : g_bad_flag
         $error("reload_timer: FLAG_BIT must sit below the top data bit");
      end
   endgenerate

   logic [CNT_W-1:0] cnt, reload, load_val;
   logic             load, cont, ena, rd_ack, wr_ack, uflow, flag;

   reload_timer_regs #(
      .SEL_W    (SEL_W),
      .BYTE_W   (BYTE_W),
      .MODE_BIT (MODE_BIT),
      .FLAG_BIT (FLAG_BIT)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (sel),
      .rd       (rd),
      .wr       (wr),
      .wdata    (wdata),
      .cnt      (cnt),
      .flag     (flag),
      .rdata    (rdata),
      .reload   (reload),
      .load_val (load_val),
      .load     (load),
      .cont     (cont),
      .ena      (ena),
      .rd_ack   (rd_ack),
      .wr_ack   (wr_ack)
   );

   reload_timer_cnt #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .reload   (reload),
      .cont     (cont),
      .cnt      (cnt),
      .uflow    (uflow)
   );

   reload_timer_irq #(
      .IRQ_REG (IRQ_REG)
   ) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .uflow  (uflow),
      .cont   (cont),
      .load   (load),
      .rd_ack (rd_ack),
      .wr_ack (wr_ack),
      .ena    (ena),
      .flag   (flag),
      .irq_n  (irq_n)
   );

   // R10
   irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!IRQ_REG && sel == SEL_W'(RG_FLAG)) |-> (irq_n == !rdata[BYTE_W-1]));

endmodule

// File: tb/reload_timer_bench.sv
`timescale 1ns/100ps
module reload_timer_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] sel = '0;
   logic       rd = 1'b0;
   logic       wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq_n;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #2.5 clk = ~clk;

   reload_timer u_reload_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (sel),
      .rd    (rd),
      .wr    (wr),
      .wdata (wdata),
      .rdata (rdata),
      .irq_n (irq_n)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops one expected byte per read cycle
   always @(negedge clk) begin
      #2;
      if (rd) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "scoreboard-empty", rdata, 0);
         end else begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(rdata == e, t, rdata, e);
         end
      end
   end

   // driver tasks: entered at a falling edge, leave one cycle later
   task automatic bw(input logic [2:0] a, input logic [7:0] d);
      sel = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic br(input logic [2:0] a, input logic [7:0] e, input string t);
      sel = a; rd = 1'b1;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic idle(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic pin(input logic e, input string t);
      #1;
      chk(irq_n == e, t, irq_n, e);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      pin(1'b1, "R1 irq_n");
      br(3'd5, 8'h00, "R1 flag reg");
      br(3'd6, 8'h80, "R1 enable reg");
      br(3'd4, 8'h00, "R1 mode reg");
      br(3'd0, 8'hFF, "R1 reload lo");
      br(3'd1, 8'hFF, "R1 reload hi");

      // self-reload, N=5: period 7
      bw(3'd0, 8'h05);
      bw(3'd4, 8'h40);
      bw(3'd3, 8'h00);                    // j=0, count 5
      br(3'd2, 8'h05, "R4 count lo");     // j=0
      br(3'd3, 8'h00, "R4 count hi");     // j=1
      idle(4);                            // j=6, count FFFF
      br(3'd3, 8'hFF, "R4 hi during wrap");
      pin(1'b1, "R10 masked irq");        // j=7
      br(3'd5, 8'h40, "R10 flag masked");
      bw(3'd6, 8'hC0);                    // j=8 -> 9
      pin(1'b0, "R9 enable set");
      br(3'd5, 8'hC0, "R10 flag+active"); // j=9
      br(3'd2, 8'h02, "R7 count lo read");// j=10
      pin(1'b1, "R7 read clears");        // j=11
      br(3'd5, 8'h00, "R7 flag cleared");
      pin(1'b1, "R5 before period end");  // j=12
      idle(1);                            // j=13
      pin(1'b0, "R5 period N+2");
      bw(3'd5, 8'h00);                    // j=14
      pin(1'b0, "R8 zero bit keeps");
      bw(3'd5, 8'h40);                    // j=15
      pin(1'b1, "R8 one bit clears");
      idle(4);                            // j=19, count 0
      br(3'd2, 8'h00, "R7 read at zero");
      pin(1'b0, "R7 set wins");           // j=20
      br(3'd5, 8'hC0, "R7 set wins reg");
      bw(3'd6, 8'h40);                    // j=22
      pin(1'b1, "R9 enable cleared");
      br(3'd5, 8'h40, "R9 flag kept");
      br(3'd6, 8'h80, "R9 enable reg");

      // single shot, N=3, with a pending flag before the restart
      bw(3'd4, 8'h00);
      bw(3'd0, 8'h03);
      bw(3'd6, 8'hC0);
      pin(1'b0, "R9 pending before restart");
      bw(3'd3, 8'h00);                    // m=0
      pin(1'b1, "R3 restart clears");
      idle(3);                            // m=3
      pin(1'b1, "R6 before underflow");
      idle(1);                            // m=4
      pin(1'b0, "R6 first underflow");
      br(3'd3, 8'hFF, "R6 no reload hi"); // m=4
      br(3'd2, 8'hFE, "R6 keeps counting");// m=5
      bw(3'd2, 8'h10);                    // m=6 -> 7
      br(3'd2, 8'hFC, "R2 count untouched");
      br(3'd0, 8'h10, "R2 reload lo set");// m=8
      pin(1'b1, "R2 no start");           // m=9
      idle(65532);                        // m=65541
      pin(1'b1, "R6 second underflow ignored");
      br(3'd5, 8'h00, "R6 flag stays clear");

      // restart with a new high byte
      bw(3'd3, 8'h01);                    // count 0x0110
      br(3'd2, 8'h10, "R3 load lo");
      br(3'd3, 8'h01, "R3 load hi");
      br(3'd1, 8'h01, "R3 reload hi set");
      idle(2);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule